// File: doc/BRIEF.md
# Encrypted Flash Write Staging Controller

This block sits between a CPU register bus and the write path of a serial flash. Software first loads a target flash address and eight 32-bit plaintext words through a small register file. It then writes a start bit. The block passes the eight words, with a key selector, to an external cipher engine over a valid/ready handshake. It stores the eight-word ciphertext that comes back and raises a done flag. Software polls that flag.

When the flash write path later issues an eight-word write, the block decides which data goes out. The stored ciphertext replaces the caller's data only if all of these hold:
- a staged result is valid;
- the global encrypt-enable input is high;
- the write address equals the staged address.

In every other case the caller's data goes out unchanged. A staged result is used at most once. Any new address or buffer write also discards it, so old ciphertext never reaches the flash.

The key selector depends on a tweak configuration input. When the tweak is all zeros, the selector is a single constant, so one key serves every address. When the tweak is nonzero, the selector is the 32-byte block number of the staged address, which gives each eight-word block its own key.

Top module: `flash_cipher_stager`

Register map (`reg_sel`):
- 0 to 7: plaintext buffers.
- 8: target address.
- 9: start control, using bit 0.
- 10: status, read-only. Bit 0 is done, bit 1 is busy, bit 2 is alignment error, bit 3 is staged-result valid.

## Requirements
- R1: A start write is ignored while `sys_encrypt_en` is low: busy stays 0 and `cph_in_valid` stays 0. A flash write issued while `sys_encrypt_en` is low always passes its own data, with `fw_out_enc` = 0.
- R2: A write to the address register (sel 8) stores the value with its low 5 bits forced to zero. The write sets status bit 2 when any of those 5 bits was nonzero and clears bit 2 when all were zero.
- R3: Buffer sel k (k = 0..7) reads back as written and drives bits [32k+31:32k] of `cph_in_block`, so buffer 0 is the lowest-addressed word.
- R4: Writing 1 to bit 0 of sel 9 while idle and enabled raises `cph_in_valid` in the next cycle. The signal holds until `cph_in_ready` is sampled high. The eight-word `cph_out_block` is captured on the cycle when `cph_out_valid` is high.
- R5: Status bit 1 (busy) is 1 from the cycle after an accepted start until the result is captured. Status bits 0 (done) and 3 (staged valid) read 1 in the cycle after the result is captured.
- R6: A flash write whose address equals the staged address, while a result is staged and the block is enabled, returns the stored ciphertext on `fw_out_data` one cycle later with `fw_out_enc` = 1. The write's own data is discarded.
- R7: When no result is staged, a flash write returns its own data on `fw_out_data` one cycle later with `fw_out_enc` = 0.
- R8: `cph_key_sel` is 0 when `tweak_cfg` is 0. Otherwise it is address bits [ADDR_W-1:5].
- R9: While busy, a further start write and any write to the buffer or address registers are ignored.
- R10: Staged valid (status bit 3) clears after one substitution. It also clears on an accepted write to any buffer or to the address register.
- R11: An accepted start clears done (status bit 0) in the next cycle.
- R12: A flash write whose address differs from the staged address passes its own data (`fw_out_enc` = 0) and leaves staged valid at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_encrypt_en | input | 1 | Global encrypt-enable from system configuration |
| tweak_cfg | input | TWEAK_W | Key-tweak configuration; zero selects one key for all addresses |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Read data for the register named by `reg_sel` |
| cph_in_valid | output | 1 | Plaintext block offered to the cipher engine |
| cph_in_ready | input | 1 | Cipher engine accepts the block |
| cph_in_block | output | N_WORDS*WORD_W | Plaintext block, word k at bits [32k+31:32k] |
| cph_key_sel | output | ADDR_W-5 | Key selector for the cipher engine |
| cph_out_valid | input | 1 | Ciphertext returned by the engine |
| cph_out_block | input | N_WORDS*WORD_W | Ciphertext block |
| fw_valid | input | 1 | Flash write path issues an eight-word write |
| fw_addr | input | ADDR_W | Flash write address |
| fw_data | input | N_WORDS*WORD_W | Caller-supplied write data |
| fw_out_valid | output | 1 | Outgoing write data valid |
| fw_out_data | output | N_WORDS*WORD_W | Data sent to flash |
| fw_out_enc | output | 1 | Outgoing data is the staged ciphertext |

## Verification
The cipher result can arrive in the same cycle as a flash write to the staged address. The bench provokes this by raising `cph_out_valid` and `fw_valid`, with the matching address, on the same edge. The rule for that cycle is that the write sees the state before capture. The bench therefore expects the caller's plain data with `fw_out_enc` = 0, and expects the next matching write to carry the ciphertext. A second overlap is a register write while an encryption is in flight. The bench checks that the buffer contents and the data given to the cipher are unchanged.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_ADDR   = 4'd8;
    localparam logic [SEL_W-1:0] SEL_START  = 4'd9;
    localparam logic [SEL_W-1:0] SEL_STATUS = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
    import fcs_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int OFF_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                sel,
    input  logic [WORD_W-1:0]               wdata,
    output logic [N_WORDS-1:0][WORD_W-1:0]  bufs,
    output logic [ADDR_W-1:0]               addr_q,
    output logic                            align_err,
    output logic                            buf_wr,
    output logic                            addr_wr
);
    localparam int IDX_W = $clog2(N_WORDS);

    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] bufs;
        logic [ADDR_W-1:0]              addr;
        logic                           aerr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        buf_wr  = 1'b0;
        addr_wr = 1'b0;
        if (wr_en) begin
            if (sel < SEL_W'(N_WORDS)) begin
                r_d.bufs[sel[IDX_W-1:0]] = wdata;
                buf_wr = 1'b1;
            end else if (sel == SEL_ADDR) begin
                r_d.addr = {wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                r_d.aerr = |wdata[OFF_W-1:0];
                addr_wr  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bufs      = r_q.bufs;
    assign addr_q    = r_q.addr;
    assign align_err = r_q.aerr;

    AST_UNALIGNED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ADDR && |wdata[OFF_W-1:0]) |=> (align_err && addr_q[OFF_W-1:0] == '0)); // R2
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int BLK_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             clr_stage,
    input  logic             take,
    input  logic             cph_in_ready,
    input  logic             cph_out_valid,
    input  logic [BLK_W-1:0] cph_out_block,
    output logic             cph_in_valid,
    output logic             busy,
    output logic             done,
    output logic             staged_valid,
    output logic [BLK_W-1:0] result
);
    typedef struct packed {
        ctl_state_e       st;
        logic             done;
        logic             stv;
        logic [BLK_W-1:0] res;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    c_d.st   = ST_SEND;
                    c_d.done = 1'b0;
                    c_d.stv  = 1'b0;
                end else if (clr_stage || take) begin
                    c_d.stv  = 1'b0;
                end
            end
            ST_SEND: begin
                if (cph_in_ready) c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cph_out_valid) begin
                    c_d.res  = cph_out_block;
                    c_d.done = 1'b1;
                    c_d.stv  = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cph_in_valid = (c_q.st == ST_SEND);
    assign busy         = (c_q.st != ST_IDLE);
    assign done         = c_q.done;
    assign staged_valid = c_q.stv;
    assign result       = c_q.res;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_in_valid && !cph_in_ready) |=> cph_in_valid); // R4
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy) |=> (busy && !done && !staged_valid)); // R11
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cph_in_valid && start_req && !cph_out_valid) |=> (busy && !cph_in_valid)); // R9
endmodule

// File: rtl/fcs_wpath.sv
module fcs_wpath #(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fw_valid,
    input  logic [ADDR_W-1:0] fw_addr,
    input  logic [BLK_W-1:0]  fw_data,
    input  logic              staged_valid,
    input  logic [ADDR_W-1:0] staged_addr,
    input  logic [BLK_W-1:0]  cipher,
    output logic              take,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_data,
    output logic              out_enc
);
    typedef struct packed {
        logic             vld;
        logic             enc;
        logic [BLK_W-1:0] data;
    } wp_t;

    wp_t w_d, w_q;

    always_comb begin
        take  = enable && fw_valid && staged_valid && (fw_addr == staged_addr);
        w_d   = w_q;
        w_d.vld = fw_valid;
        w_d.enc = take;
        if (fw_valid) w_d.data = take ? cipher : fw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign out_valid = w_q.vld;
    assign out_enc   = w_q.enc;
    assign out_data  = w_q.data;

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_valid && !staged_valid) |=> (out_valid && !out_enc && out_data == $past(fw_data))); // R7
    AST_MISMATCH_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_valid && fw_addr != staged_addr) |=> (!out_enc && out_data == $past(fw_data))); // R12
    AST_DISABLED_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_valid && !enable) |=> !out_enc); // R1
endmodule

// File: rtl/flash_cipher_stager.sv
module flash_cipher_stager
    import fcs_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    parameter int TWEAK_W = 4,
    localparam int BLK_W  = N_WORDS * WORD_W,
    localparam int OFF_W  = $clog2(BLK_W / 8),
    localparam int KSEL_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sys_encrypt_en,
    input  logic [TWEAK_W-1:0] tweak_cfg,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               cph_in_valid,
    input  logic               cph_in_ready,
    output logic [BLK_W-1:0]   cph_in_block,
    output logic [KSEL_W-1:0]  cph_key_sel,
    input  logic               cph_out_valid,
    input  logic [BLK_W-1:0]   cph_out_block,
    input  logic               fw_valid,
    input  logic [ADDR_W-1:0]  fw_addr,
    input  logic [BLK_W-1:0]   fw_data,
    output logic               fw_out_valid,
    output logic [BLK_W-1:0]   fw_out_data,
    output logic               fw_out_enc
);
    localparam int IDX_W = $clog2(N_WORDS);

    logic [N_WORDS-1:0][WORD_W-1:0] bufs;
    logic [ADDR_W-1:0]              addr_q;
    logic                           align_err, buf_wr, addr_wr;
    logic                           busy, done, staged_valid, take;
    logic                           start_req, regs_we;
    logic [BLK_W-1:0]               result;

    assign regs_we   = reg_we && !busy;
    assign start_req = reg_we && (reg_sel == SEL_START) && reg_wdata[0] && sys_encrypt_en;

    fcs_regs #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .OFF_W  (OFF_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (regs_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .bufs     (bufs),
        .addr_q   (addr_q),
        .align_err(align_err),
        .buf_wr   (buf_wr),
        .addr_wr  (addr_wr)
    );

    fcs_ctrl #(.BLK_W(BLK_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .clr_stage    (buf_wr || addr_wr),
        .take         (take),
        .cph_in_ready (cph_in_ready),
        .cph_out_valid(cph_out_valid),
        .cph_out_block(cph_out_block),
        .cph_in_valid (cph_in_valid),
        .busy         (busy),
        .done         (done),
        .staged_valid (staged_valid),
        .result       (result)
    );

    fcs_wpath #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_wpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (sys_encrypt_en),
        .fw_valid    (fw_valid),
        .fw_addr     (fw_addr),
        .fw_data     (fw_data),
        .staged_valid(staged_valid),
        .staged_addr (addr_q),
        .cipher      (result),
        .take        (take),
        .out_valid   (fw_out_valid),
        .out_data    (fw_out_data),
        .out_enc     (fw_out_enc)
    );

    assign cph_in_block = bufs;
    assign cph_key_sel  = (tweak_cfg == '0) ? '0 : addr_q[ADDR_W-1:OFF_W];

    always_comb begin
        reg_rdata = '0;
        if (reg_sel < SEL_W'(N_WORDS))  reg_rdata = bufs[reg_sel[IDX_W-1:0]];
        else if (reg_sel == SEL_ADDR)   reg_rdata = WORD_W'(addr_q);
        else if (reg_sel == SEL_STATUS) reg_rdata = {{(WORD_W-4){1'b0}}, staged_valid, align_err, busy, done};
    end

    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_encrypt_en && !busy) |=> !busy); // R1
    AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !staged_valid); // R10
    AST_CIPHER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (fw_out_enc && fw_out_data == $past(result))); // R6
endmodule

// File: tb/flash_cipher_stager_tb.sv
`timescale 1ns/1ps
module flash_cipher_stager_tb;
    localparam int ADDR_W = 24;
    localparam int WORD_W = 32;
    localparam int NW     = 8;
    localparam int BLK    = NW * WORD_W;
    localparam int KS_W   = ADDR_W - 5;

    // {addr[23:0], tweak[3:0], match, latency[1:0]}
    localparam logic [30:0] VECS [0:3] = '{
        {24'h001240, 4'h0, 1'b1, 2'd1},
        {24'h3FFFE0, 4'h3, 1'b1, 2'd3},
        {24'h000020, 4'h1, 1'b0, 2'd0},
        {24'hA55A00, 4'h8, 1'b1, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sys_encrypt_en = 1'b0;
    logic [3:0]        tweak_cfg = '0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_sel = '0;
    logic [WORD_W-1:0] reg_wdata = '0;
    logic [WORD_W-1:0] reg_rdata;
    logic              cph_in_valid;
    logic              cph_in_ready = 1'b0;
    logic [BLK-1:0]    cph_in_block;
    logic [KS_W-1:0]   cph_key_sel;
    logic              cph_out_valid = 1'b0;
    logic [BLK-1:0]    cph_out_block = '0;
    logic              fw_valid = 1'b0;
    logic [ADDR_W-1:0] fw_addr = '0;
    logic [BLK-1:0]    fw_data = '0;
    logic              fw_out_valid;
    logic [BLK-1:0]    fw_out_data;
    logic              fw_out_enc;

    int checks = 0;
    int failures = 0;
    logic [BLK-1:0]  cap_in;
    logic [KS_W-1:0] cap_ks;

    always #2.5 clk = ~clk;

    flash_cipher_stager u_dut (
        .clk(clk), .rst_n(rst_n), .sys_encrypt_en(sys_encrypt_en), .tweak_cfg(tweak_cfg),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cph_in_valid(cph_in_valid), .cph_in_ready(cph_in_ready), .cph_in_block(cph_in_block),
        .cph_key_sel(cph_key_sel), .cph_out_valid(cph_out_valid), .cph_out_block(cph_out_block),
        .fw_valid(fw_valid), .fw_addr(fw_addr), .fw_data(fw_data),
        .fw_out_valid(fw_out_valid), .fw_out_data(fw_out_data), .fw_out_enc(fw_out_enc)
    );

    function automatic logic [WORD_W-1:0] kw(input logic [KS_W-1:0] ks);
        return 32'h5A3C96E1 ^ {13'b0, ks};
    endfunction

    function automatic logic [BLK-1:0] keyblk(input logic [KS_W-1:0] ks);
        return {NW{kw(ks)}};
    endfunction

    function automatic logic [WORD_W-1:0] pat(input int i, input int k);
        return 32'h3C000000 + (i << 16) + k * 32'h0101 + 32'h11;
    endfunction

    function automatic logic [BLK-1:0] patblk(input int i);
        logic [BLK-1:0] b;
        for (int k = 0; k < NW; k++) b[k*WORD_W +: WORD_W] = pat(i, k);
        return b;
    endfunction

    function automatic logic [KS_W-1:0] exp_ks(input logic [ADDR_W-1:0] a, input logic [3:0] t);
        return (t == 4'h0) ? '0 : a[ADDR_W-1:5];
    endfunction

    task automatic check(input bit ok, input string req, input logic [BLK-1:0] act, input logic [BLK-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] sel, input logic [WORD_W-1:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] sel, output logic [WORD_W-1:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic load_block(input int i, input logic [ADDR_W-1:0] a);
        for (int k = 0; k < NW; k++) reg_write(4'(k), pat(i, k));
        reg_write(4'd8, WORD_W'(a));
    endtask

    task automatic run_cipher(input int lat);
        int guard = 0;
        while (!cph_in_valid && guard < 20) begin @(negedge clk); guard++; end
        cap_in = cph_in_block;
        cap_ks = cph_key_sel;
        cph_in_ready = 1'b1;
        @(negedge clk);
        cph_in_ready = 1'b0;
        repeat (lat) @(negedge clk);
        cph_out_block = cap_in ^ keyblk(cap_ks);
        cph_out_valid = 1'b1;
        @(negedge clk);
        cph_out_valid = 1'b0;
    endtask

    task automatic flash_write(input logic [ADDR_W-1:0] a, input logic [BLK-1:0] d,
                               output logic [BLK-1:0] o, output logic e);
        fw_valid = 1'b1; fw_addr = a; fw_data = d;
        @(negedge clk);
        fw_valid = 1'b0;
        o = fw_out_data;
        e = fw_out_enc;
    endtask

    task automatic stage(input int i, input logic [ADDR_W-1:0] a);
        load_block(i, a);
        reg_write(4'd9, 32'h1);
        run_cipher(1);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] v;
        logic [BLK-1:0]    o, exp;
        logic              e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        read_reg(4'd10, v);
        check(v == 0 && !cph_in_valid && !fw_out_valid, "reset status", BLK'(v), 0);
        read_reg(4'd0, v);
        check(v == 0, "reset buffer", BLK'(v), 0);

        // R7: nothing staged, data passes
        sys_encrypt_en = 1'b1;
        flash_write(24'h0, {NW{32'hCAFEF00D}}, o, e);
        check(o == {NW{32'hCAFEF00D}} && !e, "R7 plain pass", o, {NW{32'hCAFEF00D}});

        // R1: start ignored when disabled
        sys_encrypt_en = 1'b0;
        load_block(9, 24'h000400);
        reg_write(4'd9, 32'h1);
        read_reg(4'd10, v);
        check(v[1] == 1'b0 && !cph_in_valid, "R1 start ignored", BLK'(v), 0);
        sys_encrypt_en = 1'b1;

        // R2: unaligned address masked and flagged, aligned write clears flag
        reg_write(4'd8, 32'h001234);
        read_reg(4'd8, v);
        check(v == 32'h001220, "R2 address masked", BLK'(v), BLK'(32'h001220));
        read_reg(4'd10, v);
        check(v[2] == 1'b1, "R2 error flag set", BLK'(v[2]), 1);
        reg_write(4'd8, 32'h001240);
        read_reg(4'd10, v);
        check(v[2] == 1'b0, "R2 error flag clear", BLK'(v[2]), 0);

        // table walk: R3 R4 R5 R6 R8 R10 R12
        for (int i = 0; i < 4; i++) begin
            logic [ADDR_W-1:0] a;
            logic [3:0]        t;
            logic              m;
            int                lat;
            a = VECS[i][30:7]; t = VECS[i][6:3]; m = VECS[i][2]; lat = int'(VECS[i][1:0]);
            tweak_cfg = t;
            load_block(i, a);
            read_reg(4'd5, v);
            check(v == pat(i, 5), "R3 buffer readback", BLK'(v), BLK'(pat(i, 5)));
            reg_write(4'd9, 32'h1);
            read_reg(4'd10, v);
            check(v[1] && !v[0] && cph_in_valid, "R4 start raises request", BLK'(v), 2);
            run_cipher(lat);
            check(cap_in == patblk(i), "R3 word order to cipher", cap_in, patblk(i));
            check(cap_ks == exp_ks(a, t), "R8 key select", BLK'(cap_ks), BLK'(exp_ks(a, t)));
            read_reg(4'd10, v);
            check(v[3:0] == 4'b1001, "R5 done and staged", BLK'(v), 9);
            exp = m ? (patblk(i) ^ keyblk(exp_ks(a, t))) : ~patblk(i);
            flash_write(m ? a : a + 24'h20, ~patblk(i), o, e);
            check(o == exp && e == m, m ? "R6 substitution" : "R12 mismatch plain", o, exp);
            read_reg(4'd10, v);
            check(v[3] == !m, m ? "R10 cleared after use" : "R12 staged kept", BLK'(v[3]), BLK'(!m));
            if (!m) begin
                reg_write(4'd8, WORD_W'(a));
                read_reg(4'd10, v);
                check(v[3] == 1'b0, "R10 cleared by address write", BLK'(v[3]), 0);
            end
        end
        tweak_cfg = 4'h0;

        // R10: second matching write after a substitution passes plain
        stage(5, 24'h000800);
        flash_write(24'h000800, '1, o, e);
        check(e == 1'b1, "R6 first write substitutes", BLK'(e), 1);
        flash_write(24'h000800, {NW{32'h600DD00D}}, o, e);
        check(o == {NW{32'h600DD00D}} && !e, "R10 single use", o, {NW{32'h600DD00D}});

        // R10: buffer write discards staged result
        stage(6, 24'h000840);
        reg_write(4'd3, 32'h12345678);
        flash_write(24'h000840, {NW{32'h0F0F0F0F}}, o, e);
        check(o == {NW{32'h0F0F0F0F}} && !e, "R10 buffer write discards", o, {NW{32'h0F0F0F0F}});

        // R1: disabled write path passes data even when staged
        stage(7, 24'h000880);
        sys_encrypt_en = 1'b0;
        flash_write(24'h000880, {NW{32'hABCDEF01}}, o, e);
        check(o == {NW{32'hABCDEF01}} && !e, "R1 disabled no substitution", o, {NW{32'hABCDEF01}});
        sys_encrypt_en = 1'b1;

        // R11: new start clears done
        reg_write(4'd9, 32'h1);
        read_reg(4'd10, v);
        check(v[3:0] == 4'b0010, "R11 done cleared on start", BLK'(v), 2);
        run_cipher(0);

        // R9: start and register writes while busy are ignored
        load_block(2, 24'h000900);
        reg_write(4'd9, 32'h1);
        cph_in_ready = 1'b1;
        @(negedge clk);
        cph_in_ready = 1'b0;
        reg_write(4'd9, 32'h1);
        reg_write(4'd0, 32'hDEADBEEF);
        reg_write(4'd8, 32'h000FE0);
        read_reg(4'd10, v);
        check(v[1] && !cph_in_valid, "R9 start while busy ignored", BLK'(v), 2);
        read_reg(4'd0, v);
        check(v == pat(2, 0), "R9 buffer write while busy ignored", BLK'(v), BLK'(pat(2, 0)));
        read_reg(4'd8, v);
        check(v == 32'h000900, "R9 address write while busy ignored", BLK'(v), BLK'(32'h000900));

        // collision: result capture and matching flash write in one cycle
        cph_out_block = patblk(2) ^ keyblk('0);
        cph_out_valid = 1'b1;
        fw_valid = 1'b1; fw_addr = 24'h000900; fw_data = {NW{32'h13579BDF}};
        @(negedge clk);
        cph_out_valid = 1'b0; fw_valid = 1'b0;
        check(fw_out_data == {NW{32'h13579BDF}} && !fw_out_enc, "R7 collision plain", fw_out_data, {NW{32'h13579BDF}});
        read_reg(4'd10, v);
        check(v[3:0] == 4'b1001, "R5 staged after collision", BLK'(v), 9);
        flash_write(24'h000900, '0, o, e);
        check(o == (patblk(2) ^ keyblk('0)) && e, "R6 after collision", o, patblk(2) ^ keyblk('0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule